// File: doc/BRIEF.md
# Per-Core Idle Power Sequencer

This block sits next to one CPU core and runs a low-power sequence each time the core reports that it is waiting for an interrupt. Software picks one of four depths by writing a small mode register: light standby with clock gating, retention at a reduced supply, standalone power-down of the core, or full power collapse. A power collapse also tells the cluster that this core allows deeper system sleep. The sequencer drives a clock gate, a retention voltage request, a power switch enable, a core reset and a cache low-power request. It treats the regulator, the power switch and the cache hierarchy as request/acknowledge partners.

When the wake interrupt arrives, the steps are undone in reverse order. The supply comes back first. The cache hierarchy must then confirm that it has left its low-power state. Only after that is the clock ungated and, after a power-down, the core reset released so that the core warm-boots. A wake that arrives during the entry steps cancels the entry and undoes only what was already done. Every wait on a supply or power switch acknowledge is bounded by a programmable timeout. A timeout sets a sticky error bit and the sequence moves on. Each time the sequencer returns the core to run, the programmed mode drops back to standby.

Top module: `idle_seq`

## Requirements
- R1: Only `wfi` starts a sequence. While the sequencer is running (state code 0) and `wfi` is low, the state and all power outputs stay unchanged, whatever `wake_irq` does.
- R2: Mode 0 (standby) gates the clock and raises `cache_lp_req`, leaves `vret_req` low and `pwr_en` high, and holds in the wait state (code 4) until `wake_irq`.
- R3: On the way out of every mode, `clk_gate` falls only after `cache_lp_ack` reads low. While the acknowledge stays high, the sequencer holds in the cache-confirm state (code 7).
- R4: Mode 1 (retention) raises `vret_req` once the clock is gated. On wake it drops `vret_req`, and the clock is ungated only after `vret_ack` has returned low.
- R5: Mode 2 (standalone power-down) asserts `core_rst` and drops `pwr_en`, then waits for `pwr_ack` low. On wake it raises `pwr_en` and waits for `pwr_ack` high. It releases `core_rst` in the same cycle that `clk_gate` falls, and `core_rst` is never high while the clock runs.
- R6: Mode 3 (power collapse) behaves like mode 2 and also drives `deep_ok` high while the sequencer waits for wake. `deep_ok` is never high while `pwr_en` is high.
- R7: Each return to the running state sets the mode register back to 0 and stores the mode just run in the status field last-mode.
- R8: A `wake_irq` that arrives while the sequencer waits for a supply-lowering or power-off acknowledge cancels the entry. The sequencer goes straight to the matching restore step. Steps that were never taken are not undone.
- R9: If an acknowledge has not arrived after limit+1 cycles in a supply or switch step, the step completes anyway and sets a sticky error bit that only reset clears.
- R10: Register map at `reg_addr`: 0 is the mode in bits [1:0] (read/write), 1 is the timeout limit (read/write, reset value 16), 2 is the status (read-only; writes are ignored). Status holds the state in [3:0], the last mode in [5:4] and the error in [6]. State codes: 0 run, 1 gate, 2 lower supply, 3 power off, 4 wait, 5 power on, 6 raise supply, 7 cache confirm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi | input | 1 | Core reports wait-for-interrupt |
| wake_irq | input | 1 | Wake interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| clk_gate | output | 1 | Gate the core clock |
| vret_req | output | 1 | Request retention supply level |
| vret_ack | input | 1 | Regulator reached the requested level |
| pwr_en | output | 1 | Core power switch enable |
| pwr_ack | input | 1 | Power switch state feedback |
| core_rst | output | 1 | Core reset |
| cache_lp_req | output | 1 | Request cache low-power state |
| cache_lp_ack | input | 1 | Cache hierarchy is in low power |
| deep_ok | output | 1 | Core permits deeper cluster sleep |

## Verification
A table drives all four modes through a complete idle-and-wake cycle. It shows that each mode touches only its own outputs in the wait state: supply level, switch, reset and deep-sleep flag. It also shows that each exit leaves the same clean running state. Directed cases then hold back one acknowledge at a time. A held cache acknowledge shows that the exit gating depends on the cache. A missing regulator acknowledge combined with an early wake separates the cancel path from a timeout. A missing switch acknowledge with a short limit exposes the timeout and the sticky error. A wake without `wfi` and a write to the status address show that neither has any effect.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;
  typedef enum logic [1:0] {
    M_STBY = 2'd0, M_RET = 2'd1, M_SPC = 2'd2, M_PC = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    S_RUN = 4'd0, S_GATE = 4'd1, S_VDN = 4'd2, S_PDN = 4'd3,
    S_WAIT = 4'd4, S_PUP = 4'd5, S_VUP = 4'd6, S_CACHE = 4'd7
  } st_e;

  localparam logic [1:0] A_MODE  = 2'd0;
  localparam logic [1:0] A_LIMIT = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;

  function automatic logic cuts_power(input mode_e m);
    return (m == M_SPC) || (m == M_PC);
  endfunction

  function automatic logic is_ack_step(input st_e s);
    return (s == S_VDN) || (s == S_PDN) || (s == S_PUP) || (s == S_VUP);
  endfunction

  function automatic logic [7:0] pack_status(input st_e s, input mode_e m, input logic e);
    return {1'b0, e, m, s};
  endfunction
endpackage

// File: rtl/idle_seq_regs.sv
module idle_seq_regs
  import idle_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 8,
  parameter logic [TW-1:0] LIMIT_RST = TW'(16)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          seq_done,
  input  mode_e         done_mode,
  input  st_e           st,
  input  logic          err_set,
  output mode_e         mode,
  output logic [TW-1:0] limit
);
  mode_e last_q;
  logic  err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_STBY;
      limit  <= LIMIT_RST;
      last_q <= M_STBY;
      err_q  <= 1'b0;
    end else begin
      if (err_set) err_q <= 1'b1;
      if (seq_done) begin
        mode   <= M_STBY;
        last_q <= done_mode;
      end else if (wr && addr == A_MODE) begin
        mode <= mode_e'(wdata[1:0]);
      end
      if (wr && addr == A_LIMIT) limit <= wdata[TW-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      A_MODE:  rdata = DW'(mode);
      A_LIMIT: rdata = DW'(limit);
      A_STAT:  rdata = DW'(pack_status(st, last_q, err_q));
      default: rdata = '0;
    endcase
  end

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r7_mode_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (mode == M_STBY));
endmodule

// File: rtl/idle_seq_timer.sv
module idle_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_en,
  input  logic          step,
  input  logic [TW-1:0] limit,
  output logic          tmo
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!wait_en || step) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign tmo = wait_en && (cnt == limit);

  a_r9_idle_counter_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_en |=> (cnt == '0));
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
  import idle_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wfi,
  input  logic  wake_irq,
  input  mode_e mode,
  input  logic  vret_ack,
  input  logic  pwr_ack,
  input  logic  cache_lp_ack,
  input  logic  tmo,
  output st_e   st,
  output mode_e cur_mode,
  output logic  wait_en,
  output logic  step,
  output logic  seq_done,
  output logic  err_set,
  output logic  clk_gate,
  output logic  vret_req,
  output logic  pwr_en,
  output logic  core_rst,
  output logic  cache_lp_req,
  output logic  deep_ok
);
  st_e  nxt;
  logic did_cut;
  logic ack_ok;

  always_comb begin
    unique case (st)
      S_VDN:   ack_ok = vret_ack;
      S_PDN:   ack_ok = !pwr_ack;
      S_PUP:   ack_ok = pwr_ack;
      S_VUP:   ack_ok = !vret_ack;
      default: ack_ok = 1'b0;
    endcase
  end

  always_comb begin
    nxt = st;
    unique case (st)
      S_RUN:   if (wfi) nxt = S_GATE;
      S_GATE:
        if (wake_irq)                nxt = S_CACHE;
        else if (cur_mode == M_RET)  nxt = S_VDN;
        else if (cuts_power(cur_mode)) nxt = S_PDN;
        else                         nxt = S_WAIT;
      S_VDN:   if (wake_irq) nxt = S_VUP; else if (ack_ok || tmo) nxt = S_WAIT;
      S_PDN:   if (wake_irq) nxt = S_PUP; else if (ack_ok || tmo) nxt = S_WAIT;
      S_WAIT:
        if (wake_irq) begin
          if (cur_mode == M_RET) nxt = S_VUP;
          else if (did_cut)      nxt = S_PUP;
          else                   nxt = S_CACHE;
        end
      S_PUP:   if (ack_ok || tmo) nxt = S_CACHE;
      S_VUP:   if (ack_ok || tmo) nxt = S_CACHE;
      S_CACHE: if (!cache_lp_ack) nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RUN;
      cur_mode <= M_STBY;
      did_cut  <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_RUN && wfi) cur_mode <= mode;
      if (nxt == S_PDN) did_cut <= 1'b1;
      else if (seq_done) did_cut <= 1'b0;
    end
  end

  assign wait_en      = is_ack_step(st);
  assign step         = (nxt != st);
  assign seq_done     = (st == S_CACHE) && !cache_lp_ack;
  assign err_set      = tmo && !ack_ok;
  assign clk_gate     = (st != S_RUN);
  assign cache_lp_req = (st == S_GATE) || (st == S_VDN) || (st == S_PDN) || (st == S_WAIT);
  assign vret_req     = (cur_mode == M_RET) && ((st == S_VDN) || (st == S_WAIT));
  assign pwr_en       = !(did_cut && ((st == S_PDN) || (st == S_WAIT)));
  assign core_rst     = did_cut;
  assign deep_ok      = (st == S_WAIT) && (cur_mode == M_PC);

  a_r1_wfi_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !wfi) |=> (st == S_RUN));
  a_r2_wait_for_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !wake_irq) |=> (st == S_WAIT));
  a_r3_cache_out_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_gate) |-> !cache_lp_ack);
  a_r4_supply_back_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_gate) |-> (pwr_en && !vret_req));
  a_r5_reset_only_gated: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> clk_gate);
  a_r6_deep_only_off: assert property (@(posedge clk) disable iff (!rst_n)
    deep_ok |-> !pwr_en);
  a_r8_abort_unwinds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VDN && wake_irq) |=> (st == S_VUP));
endmodule

// File: rtl/idle_seq.sv
module idle_seq
  import idle_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 8,
  parameter logic [TW-1:0] LIMIT_RST = TW'(16)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wfi,
  input  logic          wake_irq,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          clk_gate,
  output logic          vret_req,
  input  logic          vret_ack,
  output logic          pwr_en,
  input  logic          pwr_ack,
  output logic          core_rst,
  output logic          cache_lp_req,
  input  logic          cache_lp_ack,
  output logic          deep_ok
);
  mode_e         mode, cur_mode;
  st_e           st;
  logic [TW-1:0] limit;
  logic          wait_en, step, tmo, seq_done, err_set;

  idle_seq_regs #(.DW(DW), .TW(TW), .LIMIT_RST(LIMIT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .seq_done(seq_done), .done_mode(cur_mode), .st(st),
    .err_set(err_set), .mode(mode), .limit(limit)
  );

  idle_seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .wait_en(wait_en), .step(step), .limit(limit), .tmo(tmo)
  );

  idle_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wfi(wfi), .wake_irq(wake_irq), .mode(mode),
    .vret_ack(vret_ack), .pwr_ack(pwr_ack), .cache_lp_ack(cache_lp_ack), .tmo(tmo),
    .st(st), .cur_mode(cur_mode), .wait_en(wait_en), .step(step),
    .seq_done(seq_done), .err_set(err_set), .clk_gate(clk_gate),
    .vret_req(vret_req), .pwr_en(pwr_en), .core_rst(core_rst),
    .cache_lp_req(cache_lp_req), .deep_ok(deep_ok)
  );
endmodule

// File: tb/idle_seq_bench.sv
`timescale 1ns/1ps
module idle_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi = 1'b0, wake_irq = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic clk_gate, vret_req, vret_ack, pwr_en, pwr_ack, core_rst, cache_lp_req, cache_lp_ack, deep_ok;
  logic hold_v = 1'b0, hold_p = 1'b0, hold_c = 1'b0;
  int total = 0, bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  idle_seq u_idle_seq (
    .clk(clk), .rst_n(rst_n), .wfi(wfi), .wake_irq(wake_irq), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_gate(clk_gate), .vret_req(vret_req), .vret_ack(vret_ack), .pwr_en(pwr_en),
    .pwr_ack(pwr_ack), .core_rst(core_rst), .cache_lp_req(cache_lp_req),
    .cache_lp_ack(cache_lp_ack), .deep_ok(deep_ok)
  );

  // acknowledge partners: follow their request one cycle later unless held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vret_ack <= 1'b0; pwr_ack <= 1'b1; cache_lp_ack <= 1'b0;
    end else begin
      if (!hold_v) vret_ack <= vret_req;
      if (!hold_p) pwr_ack <= pwr_en;
      if (!hold_c) cache_lp_ack <= cache_lp_req;
    end
  end

  typedef struct packed { logic [1:0] m; logic v; logic p; logic r; logic d; } vec_t;
  localparam vec_t VEC [4] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; tick(); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_wfi(); wfi = 1'b1; tick(); wfi = 1'b0; endtask
  task automatic pulse_irq(); wake_irq = 1'b1; tick(); wake_irq = 1'b0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    chk("R10 reset clk_gate", clk_gate, 0);
    chk("R10 reset pwr_en", pwr_en, 1);
    chk("R10 reset rst/vret/cache/deep", {core_rst, vret_req, cache_lp_req, deep_ok}, 0);
    rd(2'd0, rv); chk("R10 reset mode", rv, 0);
    rd(2'd1, rv); chk("R10 reset limit", rv, 16);
    rd(2'd2, rv); chk("R10 reset status", rv, 0);

    // R1: wake without wfi changes nothing
    pulse_irq(); repeat (3) tick();
    rd(2'd2, rv); chk("R1 state stays run", rv[3:0], 0);
    chk("R1 outputs idle", {clk_gate, core_rst, vret_req, cache_lp_req, pwr_en}, 5'b00001);

    // R10: status ignores writes, limit is read/write
    wr(2'd2, 8'hFF);
    rd(2'd2, rv); chk("R10 status write ignored", rv, 0);
    wr(2'd1, 8'd5);
    rd(2'd1, rv); chk("R10 limit readback", rv, 5);

    // table: every mode through a full idle/wake cycle (R2 R4 R5 R6 R7 R3)
    foreach (VEC[k]) begin
      wr(2'd0, {6'd0, VEC[k].m});
      pulse_wfi();
      repeat (8) tick();
      rd(2'd2, rv); chk($sformatf("R2 mode%0d wait state", VEC[k].m), rv[3:0], 4);
      chk($sformatf("R2 mode%0d gated", VEC[k].m), {clk_gate, cache_lp_req}, 2'b11);
      chk($sformatf("R4 mode%0d vret_req", VEC[k].m), vret_req, VEC[k].v);
      chk($sformatf("R5 mode%0d pwr_en", VEC[k].m), pwr_en, !VEC[k].p);
      chk($sformatf("R5 mode%0d core_rst", VEC[k].m), core_rst, VEC[k].r);
      chk($sformatf("R6 mode%0d deep_ok", VEC[k].m), deep_ok, VEC[k].d);
      pulse_irq();
      for (int i = 0; i < 30 && clk_gate; i++) tick();
      chk($sformatf("R3 mode%0d ungated", VEC[k].m), clk_gate, 0);
      chk($sformatf("R5 mode%0d clean exit", VEC[k].m),
          {pwr_en, vret_req, core_rst, cache_lp_req, deep_ok}, 5'b10000);
      rd(2'd0, rv); chk($sformatf("R7 mode%0d fell back", VEC[k].m), rv, 0);
      rd(2'd2, rv); chk($sformatf("R7 mode%0d last mode", VEC[k].m), rv[5:4], VEC[k].m);
      chk($sformatf("R9 mode%0d no error", VEC[k].m), rv[6], 0);
    end

    // R3: held cache acknowledge blocks ungating
    wr(2'd0, 8'd0);
    pulse_wfi(); repeat (4) tick();
    hold_c = 1'b1;
    pulse_irq(); repeat (6) tick();
    chk("R3 still gated", clk_gate, 1);
    rd(2'd2, rv); chk("R3 cache confirm state", rv[3:0], 7);
    hold_c = 1'b0; repeat (3) tick();
    chk("R3 ungated after ack", clk_gate, 0);

    // R8: wake during supply lowering aborts entry
    wr(2'd1, 8'd100);
    hold_v = 1'b1;
    wr(2'd0, 8'd1);
    pulse_wfi(); repeat (3) tick();
    rd(2'd2, rv); chk("R8 in lower-supply step", rv[3:0], 2);
    chk("R8 vret_req raised", vret_req, 1);
    pulse_irq();
    rd(2'd2, rv); chk("R8 jumped to raise-supply", rv[3:0], 6);
    repeat (6) tick();
    hold_v = 1'b0;
    rd(2'd2, rv); chk("R8 back to run", rv[3:0], 0);
    chk("R8 no error", rv[6], 0);
    chk("R8 switch untouched", {pwr_en, core_rst, vret_req, clk_gate}, 4'b1000);

    // R9: missing switch acknowledge times out
    wr(2'd1, 8'd3);
    hold_p = 1'b1;
    wr(2'd0, 8'd2);
    pulse_wfi(); repeat (12) tick();
    rd(2'd2, rv); chk("R9 timed out into wait", rv[3:0], 4);
    chk("R9 error set", rv[6], 1);
    chk("R9 powered down", {pwr_en, core_rst}, 2'b01);
    hold_p = 1'b0;
    repeat (2) tick();
    pulse_irq(); repeat (10) tick();
    rd(2'd2, rv); chk("R9 returned to run", rv[3:0], 0);
    chk("R9 error sticky", rv[6], 1);
    chk("R9 power back", {pwr_en, core_rst, clk_gate}, 3'b100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule